// File: doc/BRIEF.md
# Dual-Port Collision Arbiter with Write Inhibit

This block places a small shared memory array between two independent access ports, called left and right. Each port has an enable, a write enable, an address and write and read data. When both ports are enabled on the same address in the same cycle, the block decides which one goes ahead. The other port sees an active-low busy flag, and any write from that port is blocked before it reaches the array. A read from the blocked port is still served, and busy marks it as made during a conflict.

The strap input `masterMode` chooses the role. As master, the block arbitrates and drives both busy outputs. As slave, it does no arbitration and holds its busy outputs high. It then takes a busy input per port, and that input works only as a write inhibit. With this, several slave copies can follow the decision of one master. Accesses are registered at the rising clock edge. Read data appears after the edge that samples the read and holds the array contents from before that edge's writes.

Top module: `dual_port_arbiter`

## Requirements
- R1: In master mode, a port's busy output (active low) is low only when both ports are enabled on the same address in the current cycle; otherwise both busy outputs are high.
- R2: On a fresh collision, where neither port was enabled on that address in the previous cycle, the left port wins: `busyROutN` is low and `busyLOutN` is high. Both busy outputs are never low together.
- R3: A write from a port whose busy output is low does not change the array. A read from that port is still served.
- R4: The arbitration decision depends only on the enables and addresses. The write enables of either port do not change the busy outputs.
- R5: A port that was enabled on an address in the previous cycle keeps priority over a port newly arriving at that address. If both were already there in the previous cycle, the previous winner keeps winning.
- R6: Busy to the losing port clears in the first cycle in which the winner is disabled or on another address. A write the loser keeps presenting then lands at that cycle's edge.
- R7: In slave mode (`masterMode` = 0), both busy outputs stay high whatever the ports do.
- R8: In slave mode, a port whose busy input is low has its writes blocked and its reads served. A port whose busy input is high writes normally.
- R9: In slave mode, when both ports write the same address at the same edge without inhibit, the left port's data is stored.
- R10: In master mode, the busy inputs have no effect on writes or on the busy outputs.
- R11: During and right after reset (`rstN` low), both busy outputs are high, both read data outputs are zero, and every array word reads as zero.
- R12: For a port enabled at an edge, read data after that edge equals the word at its address before that edge's writes. For a port that is disabled, read data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| masterMode | input | 1 | 1 = master (arbitrates), 0 = slave (busy inputs inhibit writes) |
| lEn | input | 1 | Left port enable |
| lWe | input | 1 | Left port write enable |
| lAddr | input | ADDR_W | Left port address |
| lWdata | input | DATA_W | Left port write data |
| lRdata | output | DATA_W | Left port read data |
| rEn | input | 1 | Right port enable |
| rWe | input | 1 | Right port write enable |
| rAddr | input | ADDR_W | Right port address |
| rWdata | input | DATA_W | Right port write data |
| rRdata | output | DATA_W | Right port read data |
| busyLInN | input | 1 | Left write inhibit in slave mode, active low |
| busyRInN | input | 1 | Right write inhibit in slave mode, active low |
| busyLOutN | output | 1 | Left busy in master mode, active low |
| busyROutN | output | 1 | Right busy in master mode, active low |

## Verification
Two things can happen in the same cycle: the collision decision and a write by the losing port. Write inhibit only matters in the cycle where the two coincide. The bench provokes this by sweeping every address pair with varying write enables, so collisions land on cycles where the loser is writing, both with fresh arrivals and with a held address. Each cycle is judged twice. The busy outputs are compared with a priority model that tracks the previous cycle's enables, addresses and winner. The read data then shows, through later reads, whether the loser's write was kept out of the array.

// File: rtl/dpArbPkg.sv
package dpArbPkg;
  typedef struct packed {
    logic lWr;
    logic rWr;
    logic lRd;
    logic rRd;
  } memStrobes_t;
endpackage

// File: rtl/dpArbCtrl.sv
module dpArbCtrl
  import dpArbPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              lEn,
  input  logic              lWe,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              rEn,
  input  logic              rWe,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              busyLInN,
  input  logic              busyRInN,
  output memStrobes_t       strobes,
  output logic              busyLOutN,
  output logic              busyROutN
);
  // history of the previous cycle, used for holder priority
  logic              prevLEn, prevREn, prevWinR;
  logic [ADDR_W-1:0] prevLAddr, prevRAddr;

  logic collide, lHeld, rHeld, rightWins;
  logic lBusy, rBusy, lInhibit, rInhibit;

  always_comb begin
    collide   = lEn & rEn & (lAddr == rAddr);
    lHeld     = prevLEn & (prevLAddr == lAddr);
    rHeld     = prevREn & (prevRAddr == rAddr);
    // right wins only as sole holder, or as holder that won last time
    rightWins = rHeld & (~lHeld | prevWinR);
    lBusy     = masterMode & collide & rightWins;
    rBusy     = masterMode & collide & ~rightWins;
    lInhibit  = masterMode ? lBusy : ~busyLInN;
    rInhibit  = masterMode ? rBusy : ~busyRInN;
  end

  always_comb begin
    strobes.lWr = lEn & lWe & ~lInhibit;
    strobes.rWr = rEn & rWe & ~rInhibit;
    strobes.lRd = lEn;
    strobes.rRd = rEn;
    busyLOutN   = ~lBusy;
    busyROutN   = ~rBusy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLEn   <= 1'b0;
      prevREn   <= 1'b0;
      prevLAddr <= '0;
      prevRAddr <= '0;
      prevWinR  <= 1'b0;
    end else begin
      prevLEn   <= lEn;
      prevREn   <= rEn;
      prevLAddr <= lAddr;
      prevRAddr <= rAddr;
      prevWinR  <= masterMode & collide & rightWins;
    end
  end

  // R2: never both ports stalled
  p_single_loser_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(!busyLOutN && !busyROutN));
  // R3: a stalled port never produces a write strobe
  p_gate_left_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busyLOutN |-> !strobes.lWr);
  p_gate_right_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busyROutN |-> !strobes.rWr);
  // R5: a continuing collision keeps its winner
  p_hold_winner_r5: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && $past(masterMode) && lEn && rEn && lAddr == rAddr &&
     $past(lEn && rEn && lAddr == rAddr) && $stable(lAddr) && $stable(rAddr))
    |-> (busyROutN == $past(busyROutN)));
  // R7: slave never drives busy
  p_slave_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (busyLOutN && busyROutN));
  // R8: slave inhibit input blocks writes
  p_slave_inhibit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!masterMode && !busyLInN) |-> !strobes.lWr);
endmodule

// File: rtl/dpArbMem.sv
module dpArbMem
  import dpArbPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobes_t       strobes,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWdata,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWdata,
  output logic [DATA_W-1:0] lRdata,
  output logic [DATA_W-1:0] rRdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic lHit, rHit;
    assign lHit = strobes.lWr && (lAddr == ADDR_W'(i));
    assign rHit = strobes.rWr && (rAddr == ADDR_W'(i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)     words[i] <= '0;
      else if (lHit) words[i] <= lWdata;   // left takes precedence
      else if (rHit) words[i] <= rWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lRdata <= '0;
      rRdata <= '0;
    end else begin
      if (strobes.lRd) lRdata <= words[lAddr];
      if (strobes.rRd) rRdata <= words[rAddr];
    end
  end

  // R12: read data holds while its port is idle
  p_left_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.lRd) |-> $stable(lRdata));
  p_right_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.rRd) |-> $stable(rRdata));
endmodule

// File: rtl/dual_port_arbiter.sv
module dual_port_arbiter
  import dpArbPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              lEn,
  input  logic              lWe,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWdata,
  output logic [DATA_W-1:0] lRdata,
  input  logic              rEn,
  input  logic              rWe,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWdata,
  output logic [DATA_W-1:0] rRdata,
  input  logic              busyLInN,
  input  logic              busyRInN,
  output logic              busyLOutN,
  output logic              busyROutN
);
  memStrobes_t strobes;

  dpArbCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .lEn(lEn), .lWe(lWe), .lAddr(lAddr),
    .rEn(rEn), .rWe(rWe), .rAddr(rAddr),
    .busyLInN(busyLInN), .busyRInN(busyRInN),
    .strobes(strobes), .busyLOutN(busyLOutN), .busyROutN(busyROutN)
  );

  dpArbMem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .lAddr(lAddr), .lWdata(lWdata), .rAddr(rAddr), .rWdata(rWdata),
    .lRdata(lRdata), .rRdata(rRdata)
  );
endmodule

// File: tb/dual_port_arbiter_test.sv
module dual_port_arbiter_test;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode = 1'b1;
  logic lEn = 0, lWe = 0, rEn = 0, rWe = 0;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic [DW-1:0] lWdata = '0, rWdata = '0;
  logic busyLInN = 1'b1, busyRInN = 1'b1;
  logic [DW-1:0] lRdata, rRdata;
  logic busyLOutN, busyROutN;

  always #2.5 clk = ~clk;

  dual_port_arbiter #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .lEn(lEn), .lWe(lWe), .lAddr(lAddr), .lWdata(lWdata), .lRdata(lRdata),
    .rEn(rEn), .rWe(rWe), .rAddr(rAddr), .rWdata(rWdata), .rRdata(rRdata),
    .busyLInN(busyLInN), .busyRInN(busyRInN),
    .busyLOutN(busyLOutN), .busyROutN(busyROutN)
  );

  int checks = 0;
  int fails = 0;

  // bench-side model of the requirements
  logic [DW-1:0] model [DEPTH];
  logic mPrevLEn = 0, mPrevREn = 0, mPrevWinR = 0;
  logic [AW-1:0] mPrevLAddr = '0, mPrevRAddr = '0;
  logic [DW-1:0] mLR = '0, mRR = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // one cycle: drive at negedge, check busy, clock, check read data
  task automatic step(input logic le, input logic lw, input logic [AW-1:0] la,
                      input logic [DW-1:0] ld, input logic re, input logic rw,
                      input logic [AW-1:0] ra, input logic [DW-1:0] rd,
                      input string req);
    logic collide, lh, rh, winR, expBL, expBR, inhL, inhR;
    logic [DW-1:0] oldL, oldR;
    @(negedge clk);
    lEn = le; lWe = lw; lAddr = la; lWdata = ld;
    rEn = re; rWe = rw; rAddr = ra; rWdata = rd;
    #1;
    collide = le && re && (la == ra);
    lh = mPrevLEn && (mPrevLAddr == la);
    rh = mPrevREn && (mPrevRAddr == ra);
    winR = rh && (!lh || mPrevWinR);
    expBL = masterMode && collide && winR;
    expBR = masterMode && collide && !winR;
    check(busyLOutN == !expBL, {req, " busyL"}, busyLOutN, !expBL);
    check(busyROutN == !expBR, {req, " busyR"}, busyROutN, !expBR);
    inhL = masterMode ? expBL : !busyLInN;
    inhR = masterMode ? expBR : !busyRInN;
    oldL = model[la];
    oldR = model[ra];
    @(posedge clk);
    if (re && rw && !inhR) model[ra] = rd;
    if (le && lw && !inhL) model[la] = ld;   // R9: left stored last
    if (le) mLR = oldL;
    if (re) mRR = oldR;
    mPrevLEn = le; mPrevREn = re; mPrevLAddr = la; mPrevRAddr = ra;
    mPrevWinR = masterMode && collide && winR;
    #1;
    check(lRdata == mLR, {req, " R12 lRdata"}, lRdata, mLR);
    check(rRdata == mRR, {req, " R12 rRdata"}, rRdata, mRR);
  endtask

  // read every word from the left port and compare with the model
  task automatic scan(input string req);
    for (int a = 0; a < DEPTH; a++)
      step(1, 0, AW'(a), 0, 0, 0, 0, 0, req);
    step(0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    check(busyLOutN && busyROutN, "R11 busy in reset", {busyLOutN, busyROutN}, 3);
    check(lRdata == 0 && rRdata == 0, "R11 rdata in reset", {lRdata, rRdata}, 0);
    @(negedge clk) rstN = 1'b1;
    scan("R11 array cleared");

    // R1 R2 R3 R4: sweep all address pairs in master mode
    masterMode = 1'b1;
    for (int la = 0; la < DEPTH; la++)
      for (int ra = 0; ra < DEPTH; ra++)
        step(1, ((la + ra) % 4) >= 2, AW'(la), DW'(la * 16 + ra + 1),
             ((la * 3 + ra) % 5) != 0, ((la + ra) % 2) == 1, AW'(ra),
             DW'(8'hA0 ^ (ra * 7 + la)), "R1 R2 R3 sweep");
    scan("R3 array after sweep");

    // R2 fresh collision, left wins, right write blocked
    step(0, 0, 0, 0, 0, 0, 0, 0, "R2 idle");
    step(1, 0, 4'd3, 0, 1, 1, 4'd3, 8'h5A, "R2 fresh collision");
    // R4: same collision with write enables swapped, decision unchanged
    step(0, 0, 0, 0, 0, 0, 0, 0, "R4 idle");
    step(1, 1, 4'd3, 8'h11, 1, 0, 4'd3, 0, "R4 we swapped");

    // R5 right holder keeps priority; left write blocked
    step(0, 0, 0, 0, 1, 0, 4'd5, 0, "R5 right arrives");
    step(1, 1, 4'd5, 8'hC3, 1, 0, 4'd5, 0, "R5 right holds");
    step(1, 1, 4'd5, 8'hC4, 1, 0, 4'd5, 0, "R5 both held");
    // R6 right leaves, left write lands
    step(1, 1, 4'd5, 8'hC5, 0, 0, 4'd5, 0, "R6 release");
    step(0, 0, 0, 0, 1, 0, 4'd5, 0, "R6 read back");
    check(rRdata == 8'hC5, "R6 stalled write landed", rRdata, 8'hC5);

    // R10 master ignores busy inputs
    busyLInN = 1'b0; busyRInN = 1'b0;
    step(1, 1, 4'd7, 8'h77, 1, 1, 4'd8, 8'h88, "R10 busy inputs low");
    step(1, 0, 4'd8, 0, 1, 0, 4'd7, 0, "R10 read back");
    check(lRdata == 8'h88 && rRdata == 8'h77, "R10 writes landed",
          {lRdata, rRdata}, 16'h8877);

    // R7 R8 R9 slave sweep over inhibit combinations
    masterMode = 1'b0;
    for (int b = 0; b < 4; b++) begin
      busyLInN = b[0]; busyRInN = b[1];
      for (int la = 0; la < DEPTH; la++)
        for (int ra = 0; ra < DEPTH; ra += 3)
          step(1, 1, AW'(la), DW'(b * 64 + la * 4 + ra),
               1, 1, AW'(ra), DW'(8'hF0 ^ (b * 16 + ra + la)), "R7 R8 R9 slave");
      scan("R8 R9 slave array");
    end
    busyLInN = 1'b1; busyRInN = 1'b1;
    step(1, 1, 4'd9, 8'h3C, 1, 1, 4'd9, 8'hC3, "R9 same address");
    step(1, 0, 4'd9, 0, 0, 0, 0, 0, "R9 read back");
    check(lRdata == 8'h3C, "R9 left data stored", lRdata, 8'h3C);
    finishRun();
  end
endmodule